// File: doc/BRIEF.md
# Transitive Closure Engine by Repeated Squaring

This block holds a binary relation over a domain of `N` elements as an N-by-N bit matrix in registers and turns it into the relation's transitive closure. A load pulse copies a relation word into the matrix and withdraws the result-ready flag. A start pulse begins the closure. On each clock of the closure the matrix is replaced by its own composition with itself, ORed with the old matrix. After each such step, paths up to twice as long as before are covered. After `log2(N)` steps every path of up to `N` hops is covered, and the result is final.

A query side is always available. A row index and a column index select one stored bit. The same row index also gives the number of columns set in that row, which is the number of successors of that element. Query results are only meaningful while the ready flag is high. `N` must be a power of two and at least 2.

Top module: `tc_closure_engine`

## Requirements
- R1: After reset the ready flag `valid_o` is low and the stored matrix is empty, so every query returns `member_o`=0 and `count_o`=0.
- R2: A cycle with `load_i` high copies `rel_i` into the matrix and leaves `valid_o` low. Bit `i*N+j` of `rel_i` means element i relates to element j (row i, column j). Before any start, queries return the loaded bits unchanged.
- R3: A `start_i` pulse seen while idle (loaded and not ready) starts the closure. `valid_o` stays low for the next `log2(N)-1` clock edges and goes high on the `log2(N)`-th edge after the start edge.
- R4: When `valid_o` is high, bit (i,j) of the matrix is 1 exactly when element j can be reached from element i by a path of one or more hops in the loaded relation.
- R5: `count_o` equals the number of 1 bits in the stored row selected by `row_i`.
- R6: `member_o` is the stored bit at (`row_i`, `col_i`) and follows index changes within the same cycle, with no clock edge needed.
- R7: While `valid_o` is high, the matrix and `valid_o` stay unchanged until the next load. A `start_i` pulse while ready, or while the closure is running, has no effect and does not delay completion.
- R8: `load_i` overrides `start_i` in the same cycle. A load during a running closure aborts it: `valid_o` stays low and the new relation is held unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load `rel_i` into the matrix and clear ready |
| rel_i | input | N*N | Relation to load, bit i*N+j = pair (i,j) |
| start_i | input | 1 | Begin the closure from idle |
| row_i | input | log2(N) | Query row index |
| col_i | input | log2(N) | Query column index |
| member_o | output | 1 | Stored bit at (row_i, col_i) |
| count_o | output | log2(N)+1 | Number of set bits in row row_i |
| valid_o | output | 1 | Closure complete, query results final |

## Verification
A wrong step counter shows up as `valid_o` rising one or more edges early or late. An early rise exposes an unfinished matrix, which loses reachability on long chains and cycles. A wrong composition or a lost OR term shows up at the first query after `valid_o` rises, as a missing or extra bit against an independently computed closure. A row-count fault shows up on the same query as a mismatch between `count_o` and the number of set bits in the row. A fault in the control priorities shows up within one or two cycles of the pulse involved, as `valid_o` or the held matrix changing when it should not.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/tc_compose.sv
// One squaring step: out(i,j) = in(i,j) | OR_k in(i,k) & in(k,j)
module tc_compose #(
    parameter int N = 8
) (
    input  logic [N*N-1:0] mat_i,
    output logic [N*N-1:0] next_o
);
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            logic [N-1:0] hop;
            for (genvar k = 0; k < N; k++) begin : g_mid
                assign hop[k] = mat_i[i*N+k] & mat_i[k*N+j];
            end
            assign next_o[i*N+j] = (|hop) | mat_i[i*N+j];
        end
    end
endmodule

// File: rtl/tc_rowcount.sv
module tc_rowcount #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int CW = IW + 1
) (
    input  logic [N*N-1:0] mat_i,
    input  logic [IW-1:0]  row_i,
    output logic [N-1:0]   row_o,
    output logic [CW-1:0]  count_o
);
    always_comb begin
        row_o   = mat_i[row_i*N +: N];
        count_o = '0;
        for (int k = 0; k < N; k++) begin
            count_o = count_o + CW'(row_o[k]);
        end
    end
endmodule

// File: rtl/tc_closure_engine.sv
module tc_closure_engine
    import tc_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int CW = IW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [N*N-1:0] rel_i,
    input  logic           start_i,
    input  logic [IW-1:0]  row_i,
    input  logic [IW-1:0]  col_i,
    output logic           member_o,
    output logic [CW-1:0]  count_o,
    output logic           valid_o
);
    localparam int STEPS = IW;
    localparam logic [IW-1:0] LAST = IW'(STEPS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [IW-1:0]   step;
        logic [N*N-1:0]  mat;
    } state_t;

    state_t q, d;
    logic [N*N-1:0] sq_mat;
    logic [N-1:0]   row_bits;

    tc_compose #(.N(N)) u_compose (
        .mat_i  (q.mat),
        .next_o (sq_mat)
    );

    tc_rowcount #(.N(N), .IW(IW), .CW(CW)) u_rowcount (
        .mat_i   (q.mat),
        .row_i   (row_i),
        .row_o   (row_bits),
        .count_o (count_o)
    );

    always_comb begin
        d = q;
        if (load_i) begin
            d.mat   = rel_i;
            d.phase = PH_IDLE;
            d.step  = '0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (start_i) begin
                        d.phase = PH_RUN;
                        d.step  = '0;
                    end
                end
                PH_RUN: begin
                    d.mat = sq_mat;
                    if (q.step == LAST) begin
                        d.step  = '0;
                        d.phase = PH_DONE;
                    end else begin
                        d.step = q.step + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.step  <= '0;
            q.mat   <= '0;
        end else begin
            q <= d;
        end
    end

    assign member_o = row_bits[col_i];
    assign valid_o  = (q.phase == PH_DONE);

    // R8: a load always leaves the block not ready
    assert_load_clears_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !valid_o);

    // R3: step counter rests at zero outside the run phase
    assert_step_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_RUN) |-> (q.step == '0));

    // R3: an accepted start enters the run phase
    assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && start_i && !load_i) |=> (q.phase == PH_RUN));

    // R4: squaring only adds pairs, never removes one
    assert_grow_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RUN && !load_i) |=> ((q.mat & $past(q.mat)) == $past(q.mat)));

    // R7: a finished result is held until the next load
    assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !load_i) |=> (valid_o && $stable(q.mat)));

    // R5: a set member implies a non-empty row
    assert_count_member_R5: assert property (@(posedge clk) disable iff (!rst_n)
        member_o |-> (count_o != '0));
endmodule

// File: tb/sim_tc_closure_engine.sv
module sim_tc_closure_engine;
    localparam int N  = 8;
    localparam int IW = $clog2(N);
    localparam int CW = IW + 1;
    localparam int NV = 6;

    localparam logic [N*N-1:0] VEC [NV] = '{
        64'h0080402010080402,   // chain 0->1->...->7
        64'h0180402010080402,   // ring
        64'h0000000000000000,   // empty
        64'h8040201008040201,   // self loops only
        64'h0000000000080102,   // two small components
        64'hA5003C0081004210    // scattered
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_i = 1'b0;
    logic [N*N-1:0] rel_i = '0;
    logic           start_i = 1'b0;
    logic [IW-1:0]  row_i = '0;
    logic [IW-1:0]  col_i = '0;
    logic           member_o;
    logic [CW-1:0]  count_o;
    logic           valid_o;

    int checks = 0;
    int fails  = 0;

    tc_closure_engine #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .rel_i(rel_i),
        .start_i(start_i), .row_i(row_i), .col_i(col_i),
        .member_o(member_o), .count_o(count_o), .valid_o(valid_o)
    );

    always #4 clk = ~clk;

    function automatic logic [N*N-1:0] closure(input logic [N*N-1:0] r);
        logic [N*N-1:0] c = r;
        for (int k = 0; k < N; k++)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (c[i*N+k] && c[k*N+j]) c[i*N+j] = 1'b1;
        return c;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [N*N-1:0] r);
        @(negedge clk); load_i = 1'b1; rel_i = r;
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // compare every stored bit and every row count against m
    task automatic compare(input string req, input logic [N*N-1:0] m);
        for (int i = 0; i < N; i++) begin
            int ones = 0;
            row_i = IW'(i);
            for (int j = 0; j < N; j++) begin
                col_i = IW'(j);
                #1;
                check(req, $sformatf("bit(%0d,%0d)", i, j), int'(member_o), int'(m[i*N+j]));
                ones += int'(m[i*N+j]);
            end
            check("R5", $sformatf("count row %0d", i), int'(count_o), ones);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "valid after reset", int'(valid_o), 0);
        compare("R1", '0);
        rst_n = 1'b1;

        // vector table: load, check raw (R2), start, watch timing (R3), check closure (R4)
        for (int v = 0; v < NV; v++) begin
            load(VEC[v]);
            check("R2", "valid after load", int'(valid_o), 0);
            compare("R2", VEC[v]);
            start();
            for (int e = 1; e <= IW; e++) begin
                @(negedge clk);
                check("R3", $sformatf("valid after edge %0d", e), int'(valid_o), (e == IW) ? 1 : 0);
            end
            compare("R4", closure(VEC[v]));
        end

        // R6: member follows col change in the same cycle
        row_i = 3'd2; col_i = 3'd0; #1;
        check("R6", "member (2,0) scattered", int'(member_o), int'(closure(VEC[5])[16]));
        col_i = 3'd4; #1;
        check("R6", "member (2,4) scattered", int'(member_o), int'(closure(VEC[5])[20]));

        // R7: start while ready ignored, result held
        start();
        @(negedge clk);
        check("R7", "valid after start when ready", int'(valid_o), 1);
        compare("R7", closure(VEC[5]));

        // R7: start during run does not delay completion
        load(VEC[0]);
        start();
        @(negedge clk); start_i = 1'b1;      // second start during run
        @(negedge clk); start_i = 1'b0;
        check("R7", "valid at edge 2 with extra start", int'(valid_o), 0);
        @(negedge clk);
        check("R7", "valid at edge 3 with extra start", int'(valid_o), 1);

        // R8: load clears valid
        load(VEC[1]);
        check("R8", "valid after load when ready", int'(valid_o), 0);

        // R8: load and start together, load wins, nothing runs
        @(negedge clk); load_i = 1'b1; start_i = 1'b1; rel_i = VEC[0];
        @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        repeat (IW + 2) @(negedge clk);
        check("R8", "valid after load+start", int'(valid_o), 0);
        compare("R8", VEC[0]);

        // R8: load during run aborts
        load(VEC[1]);
        start();
        @(negedge clk); load_i = 1'b1; rel_i = VEC[4];
        @(negedge clk); load_i = 1'b0;
        repeat (IW + 2) @(negedge clk);
        check("R8", "valid after abort", int'(valid_o), 0);
        compare("R8", VEC[4]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule